// File: doc/BRIEF.md
# Paged Ethernet Controller Host Register Bank

This block is the 8-bit host-facing register bank of a small Ethernet controller. A host reaches it through a 4-bit offset bus with write and read strobes. Offset 0 is always the command byte. The top two bits of the command byte pick one of three register pages for every other offset. The bank holds three kinds of state:
- the receive ring pointers, the transmit buffer page and length, and the remote-transfer address and length;
- the data configuration byte, the six station-address bytes and the eight multicast filter bytes;
- an interrupt status byte with a matching enable byte, which together drive a level interrupt.

The rest of the controller uses the bank in three ways. It reads the stored values as wide outputs. It raises status bits through a set-pulse vector. It watches a one-cycle transmit request. Writing a command byte can have side effects. It can launch a transmit. It can also finish a zero-length remote transfer at once, by posting the transfer-done status bit.

Top module: `nic_regfile`

## Requirements
- R1: After the synchronous active-low reset every stored register is zero, except interrupt status, which is 0x80. The interrupt output is low.
- R2: Offset 0 reads and writes the command byte on every page. For every other offset, command bits 7:6 select the page: 0, 1 or 2. Page 2 and the invalid page 3 hold no writable register, so writes there change nothing.
- R3: The transmit length (page 0 offsets 5 low / 6 high) is a 16-bit value written one byte at a time, and so are the remote address (offsets 8 / 9) and the remote length (offsets 10 / 11). A byte write leaves the other byte unchanged.
- R4: On page 1, offsets 1 to 6 are station-address bytes 0 to 5, which appear at output bits [8k+7:8k]. Offset 7 is the current receive page. Offsets 8 to 15 are multicast bytes 0 to 7, which appear at output bits [8k+7:8k]. All of them read back.
- R5: A read returns its data on host_rdata one cycle after the read strobe. Offsets with no readable register return 0x00. The readable registers are: the command byte; page 0 offsets 3 (boundary), 4 (transmit status) and 7 (interrupt status); and page 1 offsets 1 to 15.
- R6: A write to page 0 offset 7 clears every interrupt-status bit written as 1. Bits written as 0 are left unchanged.
- R7: A set pulse on set_status[k] sets status bit k on the next edge. If the same bit is set and cleared in one cycle, the set wins.
- R8: irq is high exactly when (status AND enable mask) is non-zero. It follows a status or mask change on the edge that stores the change. The mask is page 0 offset 15.
- R9: A command write with bit 1 (start) and bit 3 or bit 4 (remote read / remote write) set, made while the remote length is zero, sets status bit 6. If the length is non-zero, or start is clear, bit 6 is not set.
- R10: A command write with bit 1 (start) and bit 2 (transmit) set produces a one-cycle tx_req on the next edge. That same edge loads transmit status with 0x01 and sets status bit 1. tx_addr is the transmit page (page 0 offset 4) times 256, and tx_len is the stored length. Transmit without start does nothing.
- R11: A pulse on soft_rst loads interrupt status with 0x80 and leaves all other registers unchanged.
- R12: The ring start (page 0 offset 1) and stop (offset 2) pages appear as byte addresses, page times 256. The boundary page (offset 3) is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one per cycle |
| host_rd | input | 1 | Read strobe; data valid next cycle |
| host_rdata | output | 8 | Registered read data |
| set_status | input | 8 | Per-bit status set pulses |
| soft_rst | input | 1 | Loads status with reset-done value |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_addr | output | 16 | Transmit buffer byte address |
| tx_len | output | 16 | Transmit length |
| ring_start | output | 16 | Ring start byte address |
| ring_stop | output | 16 | Ring stop byte address |
| boundary | output | 8 | Boundary page |
| cur_page | output | 8 | Current receive page |
| rdma_addr | output | 16 | Remote transfer start address |
| rdma_cnt | output | 16 | Remote transfer length |
| data_cfg | output | 8 | Data configuration byte |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| mcast_mask | output | 64 | Multicast filter, byte 0 in bits 7:0 |

## Verification
The assertions check, on every cycle, the causal links that the block's own activity exposes:
- that a transmit request always follows a start-plus-transmit command and arrives with transmit status 0x01;
- that status bits written as 1 are gone the cycle after a clear, and set pulses always take hold;
- that zero-length remote commands post transfer-done, and soft reset leaves status at 0x80;
- that the interrupt stays low whenever the mask is zero.

Only the directed scenarios can show the rest:
- the page decode and read-back layout;
- the byte-wise merging of the 16-bit values;
- that writes to page 2 and page 3 are ignored;
- that commands without start leave everything alone.

// File: rtl/nic_regs_pkg.sv
// Shared constants for the host register bank: index map, command and
// status bit positions. Assumes a 2-bit page field and 4-bit offsets.
package nic_regs_pkg;
    localparam int OFF_W  = 4;
    localparam int PAGE_W = 2;
    localparam int IDX_W  = OFF_W + PAGE_W;
    localparam int DW     = 8;
    localparam int N_STA  = 6;
    localparam int N_MC   = 8;
    localparam int N_PAIR = 3;

    typedef logic [IDX_W-1:0] idx_t;

    // page 0
    localparam idx_t IX_RSTART = 6'h01;
    localparam idx_t IX_RSTOP  = 6'h02;
    localparam idx_t IX_BNDRY  = 6'h03;
    localparam idx_t IX_TPAGE  = 6'h04;  // write: tx page, read: tx status
    localparam idx_t IX_STAT   = 6'h07;
    localparam idx_t IX_DCFG   = 6'h0E;
    localparam idx_t IX_MASK   = 6'h0F;
    // page 1
    localparam idx_t IX_STA0   = 6'h11;
    localparam idx_t IX_CURPG  = 6'h17;
    localparam idx_t IX_MC0    = 6'h18;

    // low-byte index of each 16-bit pair: tx length, remote addr, remote length
    localparam idx_t PAIR_LO [N_PAIR] = '{6'h05, 6'h08, 6'h0A};

    // command bits
    localparam int CB_START = 1;
    localparam int CB_XMIT  = 2;
    localparam int CB_RRD   = 3;
    localparam int CB_RWR   = 4;

    // status bits
    localparam int SB_TXOK = 1;
    localparam int SB_RDC  = 6;
    localparam logic [DW-1:0] STAT_RST = 8'h80;
    localparam logic [DW-1:0] TXS_OK   = 8'h01;
endpackage

// File: rtl/nic_addr_decode.sv
// Host address decode: forms the paged register index from the offset and
// the page bits, and splits the write strobe into command and register
// writes. Assumes offset 0 is the command byte on every page.
module nic_addr_decode #(
    parameter int OFF_W  = 4,
    parameter int PAGE_W = 2
) (
    input  logic [OFF_W-1:0]        addr,
    input  logic [PAGE_W-1:0]       page,
    input  logic                    wr,
    output logic                    is_cmd,
    output logic [OFF_W+PAGE_W-1:0] idx,
    output logic                    wr_cmd,
    output logic                    wr_reg
);
    // combinational index and strobe split
    always_comb begin
        is_cmd = (addr == '0);
        idx    = {page, addr};
        wr_cmd = wr && is_cmd;
        wr_reg = wr && !is_cmd;
    end
endmodule

// File: rtl/nic_byte_pair.sv
// A 16-bit (2*BW) value written as independent low and high bytes.
// Assumes at most one of the two strobes is active per cycle.
module nic_byte_pair #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [BW-1:0]   wdata,
    output logic [2*BW-1:0] q
);
    // byte-merge storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_lo) q[BW-1:0]    <= wdata;
            if (wr_hi) q[2*BW-1:BW] <= wdata;
        end
    end
endmodule

// File: rtl/nic_int_status.sv
// Interrupt status byte with write-one-to-clear, set pulses that win over
// clears, a soft load of the reset value, and the masked level interrupt.
module nic_int_status #(
    parameter int            W       = 8,
    parameter logic [W-1:0]  RST_VAL = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] clr_eff;

    // clear vector applies only on a status write
    always_comb clr_eff = clr_en ? clr_bits : '0;

    // status storage
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= RST_VAL;
        else if (soft_rst) status <= RST_VAL;
        else               status <= (status & ~clr_eff) | set_bits;
    end

    // masked level interrupt
    always_comb irq = |(status & mask);
endmodule

// File: rtl/nic_regfile.sv
// Top of the paged host register bank. Holds configuration registers,
// performs command side effects (transmit request, zero-length remote
// transfer completion) and presents all values to the controller.
// Assumes one host access per cycle.
module nic_regfile
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DW-1:0]     host_rdata,
    input  logic [DW-1:0]     set_status,
    input  logic              soft_rst,
    output logic              irq,
    output logic              tx_req,
    output logic [2*DW-1:0]   tx_addr,
    output logic [2*DW-1:0]   tx_len,
    output logic [2*DW-1:0]   ring_start,
    output logic [2*DW-1:0]   ring_stop,
    output logic [DW-1:0]     boundary,
    output logic [DW-1:0]     cur_page,
    output logic [2*DW-1:0]   rdma_addr,
    output logic [2*DW-1:0]   rdma_cnt,
    output logic [DW-1:0]     data_cfg,
    output logic [N_STA*DW-1:0] station_addr,
    output logic [N_MC*DW-1:0]  mcast_mask
);
    logic [DW-1:0]   cmd_q, rstart_q, rstop_q, bndry_q, tpage_q, curpg_q;
    logic [DW-1:0]   dcfg_q, mask_q, txs_q, rdata_q, rd_mux, status_q, set_all;
    logic [DW-1:0]   sta_q [N_STA];
    logic [DW-1:0]   mc_q  [N_MC];
    logic [2*DW-1:0] pair_q [N_PAIR];
    logic            is_cmd, wr_cmd, wr_reg, go_tx, rdc_zero, txreq_q;
    idx_t            idx;

    nic_addr_decode #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_dec (
        .addr(host_addr), .page(cmd_q[DW-1 -: PAGE_W]), .wr(host_wr),
        .is_cmd(is_cmd), .idx(idx), .wr_cmd(wr_cmd), .wr_reg(wr_reg)
    );

    // one byte-pair register per 16-bit value
    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        nic_byte_pair #(.BW(DW)) u_pair (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(wr_reg && idx == PAIR_LO[g]),
            .wr_hi(wr_reg && idx == PAIR_LO[g] + idx_t'(1)),
            .wdata(host_wdata), .q(pair_q[g])
        );
    end

    // command side effects decoded from the byte being written
    always_comb begin
        go_tx    = wr_cmd && host_wdata[CB_START] && host_wdata[CB_XMIT];
        rdc_zero = wr_cmd && host_wdata[CB_START]
                   && (host_wdata[CB_RRD] || host_wdata[CB_RWR])
                   && (pair_q[2] == '0);
        set_all          = set_status;
        set_all[SB_TXOK] = set_status[SB_TXOK] | go_tx;
        set_all[SB_RDC]  = set_status[SB_RDC]  | rdc_zero;
    end

    nic_int_status #(.W(DW), .RST_VAL(STAT_RST)) u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .clr_en(wr_reg && idx == IX_STAT), .clr_bits(host_wdata),
        .set_bits(set_all), .mask(mask_q), .status(status_q), .irq(irq)
    );

    // single-byte configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; rstart_q <= '0; rstop_q <= '0; bndry_q <= '0;
            tpage_q <= '0; curpg_q <= '0; dcfg_q <= '0; mask_q <= '0;
        end else begin
            if (wr_cmd) cmd_q <= host_wdata;
            if (wr_reg) begin
                case (idx)
                    IX_RSTART: rstart_q <= host_wdata;
                    IX_RSTOP:  rstop_q  <= host_wdata;
                    IX_BNDRY:  bndry_q  <= host_wdata;
                    IX_TPAGE:  tpage_q  <= host_wdata;
                    IX_DCFG:   dcfg_q   <= host_wdata;
                    IX_MASK:   mask_q   <= host_wdata;
                    IX_CURPG:  curpg_q  <= host_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // station address and multicast filter bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_STA; i++) sta_q[i] <= '0;
            for (int i = 0; i < N_MC; i++)  mc_q[i]  <= '0;
        end else if (wr_reg) begin
            for (int i = 0; i < N_STA; i++)
                if (idx == IX_STA0 + idx_t'(i)) sta_q[i] <= host_wdata;
            for (int i = 0; i < N_MC; i++)
                if (idx == IX_MC0 + idx_t'(i)) mc_q[i] <= host_wdata;
        end
    end

    // transmit request pulse and transmit status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txreq_q <= 1'b0;
            txs_q   <= '0;
        end else begin
            txreq_q <= go_tx;
            if (go_tx) txs_q <= TXS_OK;
        end
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (is_cmd) begin
            rd_mux = cmd_q;
        end else begin
            case (idx)
                IX_BNDRY: rd_mux = bndry_q;
                IX_TPAGE: rd_mux = txs_q;
                IX_STAT:  rd_mux = status_q;
                IX_CURPG: rd_mux = curpg_q;
                default:  ;
            endcase
            for (int i = 0; i < N_STA; i++)
                if (idx == IX_STA0 + idx_t'(i)) rd_mux = sta_q[i];
            for (int i = 0; i < N_MC; i++)
                if (idx == IX_MC0 + idx_t'(i)) rd_mux = mc_q[i];
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (host_rd) rdata_q <= rd_mux;
    end

    // output presentation
    always_comb begin
        host_rdata = rdata_q;
        tx_req     = txreq_q;
        tx_addr    = {tpage_q, {DW{1'b0}}};
        tx_len     = pair_q[0];
        rdma_addr  = pair_q[1];
        rdma_cnt   = pair_q[2];
        ring_start = {rstart_q, {DW{1'b0}}};
        ring_stop  = {rstop_q, {DW{1'b0}}};
        boundary   = bndry_q;
        cur_page   = curpg_q;
        data_cfg   = dcfg_q;
        for (int i = 0; i < N_STA; i++) station_addr[i*DW +: DW] = sta_q[i];
        for (int i = 0; i < N_MC; i++)  mcast_mask[i*DW +: DW]   = mc_q[i];
    end
endmodule

// File: rtl/nic_regfile_checker.sv
// Cycle-level properties of the register bank, bound into nic_regfile.
module nic_regfile_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       host_wr,
    input logic       soft_rst,
    input logic [7:0] cmd_q,
    input logic [7:0] status_q,
    input logic [7:0] set_all,
    input logic [7:0] mask_q,
    input logic [15:0] rdma_cnt,
    input logic [7:0] txs_q,
    input logic       irq,
    input logic       tx_req
);
    logic stat_wr;
    logic tx_cmd;
    logic rdc_cmd;
    always_comb begin
        stat_wr = host_wr && host_addr == 4'h7 && cmd_q[7:6] == 2'b00;
        tx_cmd  = host_wr && host_addr == 4'h0 && host_wdata[1] && host_wdata[2];
        rdc_cmd = host_wr && host_addr == 4'h0 && host_wdata[1]
                  && (host_wdata[3] || host_wdata[4]) && rdma_cnt == 16'h0;
    end

    assert_txreq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(rst_n) && $past(tx_cmd));
    assert_txstat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> txs_q == 8'h01);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_wr) && $past(set_all) == 8'h0 && !$past(soft_rst))
        |-> (status_q & $past(host_wdata)) == 8'h0);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(soft_rst))
        |-> (status_q & $past(set_all)) == $past(set_all));
    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == 8'h0 |-> !irq);
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status_q != 8'h0);
    assert_zero_len_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rdc_cmd) && !$past(soft_rst)) |-> status_q[6]);
    assert_soft_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(soft_rst)) |-> status_q == 8'h80);
endmodule

bind nic_regfile nic_regfile_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .soft_rst(soft_rst), .cmd_q(cmd_q), .status_q(status_q),
    .set_all(set_all), .mask_q(mask_q), .rdma_cnt(rdma_cnt), .txs_q(txs_q),
    .irq(irq), .tx_req(tx_req)
);

// File: tb/nic_regfile_bench.sv
`timescale 1ns/1ps
// Directed bench for the paged register bank; one task per scenario.
module nic_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0, soft_rst = 1'b0;
    logic [7:0]  set_status = '0;
    logic [7:0]  host_rdata, boundary, cur_page, data_cfg;
    logic        irq, tx_req;
    logic [15:0] tx_addr, tx_len, ring_start, ring_stop, rdma_addr, rdma_cnt;
    logic [47:0] station_addr;
    logic [63:0] mcast_mask;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nic_regfile u_nic_regfile (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic pulse_set(input logic [7:0] b);
        @(negedge clk); set_status = b;
        @(negedge clk); set_status = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 irq", irq, 0);
        check("R1 ring_start", ring_start, 0);
        check("R1 tx_len", tx_len, 0);
        rd(4'h7, d); check("R1 status", d, 8'h80);
        rd(4'h0, d); check("R1 cmd", d, 8'h00);
    endtask

    task automatic t_ring;
        logic [7:0] d;
        wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h3, 8'h4C);
        check("R12 ring_start", ring_start, 16'h4600);
        check("R12 ring_stop", ring_stop, 16'h8000);
        check("R12 boundary", boundary, 8'h4C);
        rd(4'h3, d); check("R12 boundary read", d, 8'h4C);
    endtask

    task automatic t_pairs;
        wr(4'h5, 8'h34); wr(4'h6, 8'h12);
        check("R3 tx_len", tx_len, 16'h1234);
        wr(4'h5, 8'hAA);
        check("R3 tx_len low only", tx_len, 16'h12AA);
        wr(4'h9, 8'h40); wr(4'h8, 8'h00);
        check("R3 rdma_addr", rdma_addr, 16'h4000);
        wr(4'hA, 8'h02); wr(4'hB, 8'h01);
        check("R3 rdma_cnt", rdma_cnt, 16'h0102);
    endtask

    task automatic t_page1;
        logic [7:0] d;
        wr(4'h0, 8'h40);
        for (int i = 1; i <= 6; i++) wr(i[3:0], 8'hA0 + i[7:0]);
        wr(4'h7, 8'h4D);
        for (int i = 8; i <= 15; i++) wr(i[3:0], 8'hC0 + i[7:0]);
        check("R4 station", station_addr, 48'hA6A5A4A3A2A1);
        check("R4 cur_page", cur_page, 8'h4D);
        check("R4 mcast", mcast_mask, 64'hCFCECDCCCBCAC9C8);
        rd(4'h1, d); check("R4 sta0 read", d, 8'hA1);
        rd(4'h7, d); check("R4 curpage read", d, 8'h4D);
        rd(4'hF, d); check("R4 mc7 read", d, 8'hCF);
        rd(4'h0, d); check("R2 cmd read page1", d, 8'h40);
        check("R2 ring untouched by page1", ring_start, 16'h4600);
        wr(4'h0, 8'h00); wr(4'h1, 8'h47);
        check("R2 page0 offset1 hits ring", ring_start, 16'h4700);
        check("R2 station untouched by page0", station_addr, 48'hA6A5A4A3A2A1);
    endtask

    task automatic t_unread;
        logic [7:0] d;
        rd(4'h1, d); check("R5 page0 off1 read", d, 8'h00);
        rd(4'hA, d); check("R5 page0 offA read", d, 8'h00);
        wr(4'h0, 8'h80); wr(4'h1, 8'h99); wr(4'h3, 8'h55);
        rd(4'h3, d); check("R5 page2 read", d, 8'h00);
        wr(4'h0, 8'hC0); wr(4'h3, 8'h77); wr(4'h5, 8'h66);
        rd(4'h3, d); check("R5 page3 read", d, 8'h00);
        check("R2 page2/3 writes ignored ring", ring_start, 16'h4700);
        check("R2 page2/3 writes ignored bndry", boundary, 8'h4C);
        check("R2 page3 writes ignored tx_len", tx_len, 16'h12AA);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] d;
        wr(4'hF, 8'hFF);
        check("R8 irq on", irq, 1);
        wr(4'h7, 8'h80);
        rd(4'h7, d); check("R6 clear bit7", d, 8'h00);
        check("R8 irq off", irq, 0);
        pulse_set(8'h05);
        rd(4'h7, d); check("R7 set pulse", d, 8'h05);
        check("R8 irq set", irq, 1);
        wr(4'hF, 8'h02);
        check("R8 irq masked", irq, 0);
        wr(4'h7, 8'h01);
        rd(4'h7, d); check("R6 partial clear", d, 8'h04);
        @(negedge clk); host_addr = 4'h7; host_wdata = 8'h14; host_wr = 1'b1; set_status = 8'h10;
        @(negedge clk); host_wr = 1'b0; set_status = '0;
        rd(4'h7, d); check("R7 set wins over clear", d, 8'h10);
        wr(4'h7, 8'hFF);
    endtask

    task automatic t_rdc;
        logic [7:0] d;
        wr(4'h0, 8'h0A);
        rd(4'h7, d); check("R9 nonzero count no done", d, 8'h00);
        wr(4'hA, 8'h00); wr(4'hB, 8'h00);
        wr(4'h0, 8'h08);
        rd(4'h7, d); check("R9 no start no done", d, 8'h00);
        wr(4'h0, 8'h12);
        rd(4'h7, d); check("R9 zero length done", d, 8'h40);
        wr(4'h7, 8'hFF);
    endtask

    task automatic t_tx;
        logic [7:0] d;
        rd(4'h4, d); check("R10 tx status before", d, 8'h00);
        wr(4'h4, 8'h40);
        wr(4'h0, 8'h04);
        check("R10 no start no req", tx_req, 0);
        rd(4'h7, d); check("R10 no start no status", d, 8'h00);
        wr(4'h0, 8'h06);
        check("R10 tx_req", tx_req, 1);
        check("R10 tx_addr", tx_addr, 16'h4000);
        check("R10 tx_len", tx_len, 16'h12AA);
        @(negedge clk);
        check("R10 tx_req one cycle", tx_req, 0);
        rd(4'h4, d); check("R10 tx status", d, 8'h01);
        rd(4'h7, d); check("R10 status bit1", d, 8'h02);
    endtask

    task automatic t_soft;
        logic [7:0] d;
        wr(4'h7, 8'hFF);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd(4'h7, d); check("R11 status loaded", d, 8'h80);
        check("R11 ring kept", ring_start, 16'h4700);
        check("R11 tx_len kept", tx_len, 16'h12AA);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ring();
        t_pairs();
        t_page1();
        t_unread();
        t_status();
        t_rdc();
        t_tx();
        t_soft();
        finish_run();
    end
endmodule